// File: doc/BRIEF.md
# Two-Channel Interval Timer

This block is a pair of 16-bit down-counters that share one byte-wide register port. A fractional accumulator turns the system clock into a count-enable strobe at a fixed tick rate, 1,193,180 Hz by default. Each enabled tick decrements every running channel by one. A channel expires on the tick that takes it from 1 to 0. It then either halts and raises a done code, or reloads its count and runs again, depending on its mode.

Software sets up a channel by writing a control word to the control address, then writing two data bytes, low byte first. One shared byte-phase flag serves both data addresses. The high byte therefore completes the load of whichever channel owns the address it is written to, whatever address took the low byte. Control words that ask for any access method other than low-then-high, for an unsupported counter select, or for decimal counting are rejected, and a one-cycle error strobe is raised. Reading the control address returns channel 2's status byte. Each channel also drives a one-cycle expiry pulse.

Top module: `interval_timer_pair`

States:

- **Loader FSM**
  - States: `LD_LOW` waits for a low byte; `LD_HIGH` waits for a high byte.
  - Transitions:
    - *take_low* (`LD_LOW`→`LD_HIGH`) on any data write.
    - *commit* (`LD_HIGH`→`LD_LOW`) on any data write, which loads the addressed channel.
- **Channel FSM**
  - States: `CH_IDLE` (never loaded), `CH_COUNT` (running), `CH_HALT` (mode-0 expiry reached).
  - Transitions:
    - *arm* (any state→`CH_COUNT`) on a load.
    - *rearm* (`CH_COUNT`→`CH_COUNT`) on expiry in a nonzero mode.
    - *finish* (`CH_COUNT`→`CH_HALT`) on expiry in mode 0.

## Requirements
- R1: `tick_o` pulses for one cycle at an average rate of TICK_HZ/CLK_HZ per clock. Over any window of W cycles starting at reset release, the number of pulses is within 1 of W*TICK_HZ/CLK_HZ.
- R2: A control write (address 3) is rejected with a one-cycle `cmd_err` pulse in the cycle after the write, and changes no channel, when any of these holds: bits 5:4 are not 2'b11; bit 0 is 1 (decimal counting). A legal control write leaves `cmd_err` low.
- R3: Control bits 7:6 select the channel: 2'b00 is channel 0 and 2'b10 is channel 2. The values 2'b01 and 2'b11 raise `cmd_err` and are otherwise ignored.
- R4: An accepted control word stores bits 3:1 as the selected channel's mode. Mode 0 means one-shot; every other value means periodic. A mode change takes effect at that channel's next expiry.
- R5: Data addresses are 0 (channel 0) and 2 (channel 2). A single shared flag takes the first data write as the low byte and the second as the high byte. The second write loads {high, low} into the channel of its own address, and the flag then returns to low. Writes to address 1 are ignored and do not advance the flag.
- R6: After a load of N, `expire_o[ch]` pulses for one cycle in the cycle after the Nth tick strobe seen after the load edge. Bit 0 is channel 0 and bit 1 is channel 2. A count of 0 behaves as 65,536.
- R7: A load clears the channel's status to 0x00 and restarts counting from the new value, including when it arrives mid-count.
- R8: In mode 0, expiry sets the status to 0x20 and stops the channel: there are no further expiries until the next load.
- R9: In any nonzero mode the channel reloads its count on expiry, expires again every N ticks, and its status stays 0x00.
- R10: `bus_rdata` is combinational on `bus_addr`:
  - address 3 gives channel 2's status;
  - address 0 gives channel 0's status;
  - other addresses give 0x00.
- R11: After reset both channels are idle with status 0x00, both modes are 0, the byte flag expects a low byte, and no expiry or error occurs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe for the register port |
| bus_addr | input | 2 | Register address (0 ch0 data, 1 unused, 2 ch2 data, 3 control/status) |
| bus_wdata | input | 8 | Write data byte |
| bus_rdata | output | 8 | Read data byte (status) |
| cmd_err | output | 1 | One-cycle strobe on a rejected control word |
| tick_o | output | 1 | Count-enable strobe at the tick rate |
| expire_o | output | 2 | One-cycle expiry pulse per channel (bit 0 ch0, bit 1 ch2) |

## Verification
The bench measures every expiry against the number of tick strobes seen since the load edge. A counter that is off by one, fires on the wrong edge, or lets a same-cycle tick slip past a load shows up as a mismatched tick count. A shared-flag test splits a load across both data addresses with a write to the unused address in between. A per-channel flag, or a stray write that advances the flag, would load the wrong channel or the wrong value. Rejected control words are followed by a one-shot run that would turn periodic if an illegal word had leaked through. A mid-count reload, a zero count that must last 65,536 ticks, and random loads in mixed modes cover reload priority, wrap handling and the halt-versus-repeat choice.

// File: rtl/ivt_pkg.sv
package ivt_pkg;

    typedef enum logic [0:0] {
        LD_LOW,
        LD_HIGH
    } ld_state_t;

    typedef enum logic [1:0] {
        CH_IDLE,
        CH_COUNT,
        CH_HALT
    } ch_state_t;

    localparam int unsigned NUM_CH  = 2;
    localparam int unsigned BYTE_W  = 8;
    localparam int unsigned STAT_W  = 8;

    localparam logic [1:0] A_CH0   = 2'd0;
    localparam logic [1:0] A_SPARE = 2'd1;
    localparam logic [1:0] A_CH2   = 2'd2;
    localparam logic [1:0] A_CTRL  = 2'd3;

    localparam logic [1:0] SEL_CH0 = 2'b00;
    localparam logic [1:0] SEL_CH2 = 2'b10;
    localparam logic [1:0] ACC_LH  = 2'b11;

    localparam logic [STAT_W-1:0] DONE_CODE = 8'h20;

endpackage

// File: rtl/ivt_tick_gen.sv
module ivt_tick_gen #(
    parameter int unsigned CLK_HZ  = 100_000_000,
    parameter int unsigned TICK_HZ = 1_193_180
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    localparam int unsigned ACC_W = $clog2(CLK_HZ + TICK_HZ) + 1;
    localparam logic [ACC_W-1:0] STEP  = ACC_W'(TICK_HZ);
    localparam logic [ACC_W-1:0] LIMIT = ACC_W'(CLK_HZ);

    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] sum;
    logic             wrap;

    always_comb begin
        sum  = acc_q + STEP;
        wrap = (sum >= LIMIT);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q  <= '0;
            tick_o <= 1'b0;
        end else begin
            acc_q  <= wrap ? (sum - LIMIT) : sum;
            tick_o <= wrap;
        end
    end

    // Accumulator residue always stays below the clock rate.
    assert_acc_bounded_R1: assert property (@(posedge clk) disable iff (!rst_n)
        acc_q < LIMIT);

endmodule

// File: rtl/ivt_decoder.sv
module ivt_decoder
    import ivt_pkg::*;
#(
    parameter int unsigned CNT_W  = 16,
    parameter int unsigned MODE_W = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_i,
    input  logic [1:0]            addr_i,
    input  logic [BYTE_W-1:0]     wdata_i,
    output logic [NUM_CH-1:0]     load_o,
    output logic [CNT_W-1:0]      load_val_o,
    output logic [NUM_CH-1:0]     mode_we_o,
    output logic [MODE_W-1:0]     mode_val_o,
    output logic                  cmd_err_o
);
    localparam int unsigned LOW_W = CNT_W - BYTE_W;

    ld_state_t          ld_q, ld_nxt;
    logic [LOW_W-1:0]   low_q;
    logic               data_hit;
    logic               ctl_hit;
    logic               tgt_ch2;
    logic [1:0]         sel;
    logic               method_ok;
    logic               bcd_req;
    logic               sel_ok;
    logic               err_nxt;

    always_comb begin
        data_hit  = wr_i && ((addr_i == A_CH0) || (addr_i == A_CH2));
        ctl_hit   = wr_i && (addr_i == A_CTRL);
        tgt_ch2   = (addr_i == A_CH2);
        sel       = wdata_i[7:6];
        method_ok = (wdata_i[5:4] == ACC_LH);
        bcd_req   = wdata_i[0];
        sel_ok    = (sel == SEL_CH0) || (sel == SEL_CH2);
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ld_q      <= LD_LOW;
            low_q     <= '0;
            cmd_err_o <= 1'b0;
        end else begin
            ld_q      <= ld_nxt;
            cmd_err_o <= err_nxt;
            if (data_hit && (ld_q == LD_LOW))
                low_q <= LOW_W'(wdata_i);
        end
    end

    // outputs and next state
    always_comb begin
        ld_nxt     = ld_q;
        load_o     = '0;
        load_val_o = {wdata_i, low_q};
        unique case (ld_q)
            LD_LOW: begin
                if (data_hit)
                    ld_nxt = LD_HIGH;
            end
            LD_HIGH: begin
                if (data_hit) begin
                    load_o[tgt_ch2] = 1'b1;
                    ld_nxt          = LD_LOW;
                end
            end
        endcase

        mode_val_o = wdata_i[MODE_W:1];
        mode_we_o  = '0;
        if (ctl_hit && method_ok && !bcd_req) begin
            if (sel == SEL_CH0) mode_we_o[0] = 1'b1;
            if (sel == SEL_CH2) mode_we_o[1] = 1'b1;
        end
        err_nxt = ctl_hit && (!method_ok || bcd_req || !sel_ok);
    end

    assert_err_after_ctrl_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_err_o |-> $past(wr_i && (addr_i == A_CTRL)));

    assert_one_mode_target_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(mode_we_o));

    assert_one_load_target_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(load_o));

    // A completed load is always preceded by a low-byte data write.
    assert_load_after_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (|load_o) |-> (ld_q == LD_HIGH));

endmodule

// File: rtl/ivt_channel.sv
module ivt_channel
    import ivt_pkg::*;
#(
    parameter int unsigned CNT_W  = 16,
    parameter int unsigned MODE_W = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick_i,
    input  logic               load_i,
    input  logic [CNT_W-1:0]   load_val_i,
    input  logic               mode_we_i,
    input  logic [MODE_W-1:0]  mode_val_i,
    output logic               expire_o,
    output logic [STAT_W-1:0]  status_o
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    ch_state_t           st_q, st_nxt;
    logic [CNT_W-1:0]    cnt_q, cnt_nxt;
    logic [CNT_W-1:0]    reload_q, reload_nxt;
    logic [MODE_W-1:0]   mode_q;
    logic [STAT_W-1:0]   stat_nxt;
    logic                exp_nxt;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= CH_IDLE;
            cnt_q    <= '0;
            reload_q <= '0;
            mode_q   <= '0;
            status_o <= '0;
            expire_o <= 1'b0;
        end else begin
            st_q     <= st_nxt;
            cnt_q    <= cnt_nxt;
            reload_q <= reload_nxt;
            status_o <= stat_nxt;
            expire_o <= exp_nxt;
            if (mode_we_i)
                mode_q <= mode_val_i;
        end
    end

    // next state and outputs
    always_comb begin
        st_nxt     = st_q;
        cnt_nxt    = cnt_q;
        reload_nxt = reload_q;
        stat_nxt   = status_o;
        exp_nxt    = 1'b0;
        unique case (st_q)
            CH_IDLE: begin
            end
            CH_COUNT: begin
                if (tick_i) begin
                    if (cnt_q == ONE) begin
                        exp_nxt = 1'b1;
                        if (mode_q == '0) begin
                            stat_nxt = DONE_CODE;
                            cnt_nxt  = '0;
                            st_nxt   = CH_HALT;
                        end else begin
                            cnt_nxt  = reload_q;
                        end
                    end else begin
                        cnt_nxt = cnt_q - ONE;
                    end
                end
            end
            CH_HALT: begin
            end
        endcase
        if (load_i) begin
            st_nxt     = CH_COUNT;
            cnt_nxt    = load_val_i;
            reload_nxt = load_val_i;
            stat_nxt   = '0;
            exp_nxt    = 1'b0;
        end
    end

    assert_load_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (status_o == '0));

    assert_expire_on_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
        expire_o |-> $past(tick_i));

    assert_oneshot_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (expire_o && ($past(mode_q) == '0)) |-> (status_o == DONE_CODE));

    assert_periodic_status_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (expire_o && ($past(mode_q) != '0)) |-> (status_o == '0));

endmodule

// File: rtl/interval_timer_pair.sv
module interval_timer_pair
    import ivt_pkg::*;
#(
    parameter int unsigned CLK_HZ  = 100_000_000,
    parameter int unsigned TICK_HZ = 1_193_180,
    parameter int unsigned CNT_W   = 16,
    parameter int unsigned MODE_W  = 3
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_wr,
    input  logic [1:0]  bus_addr,
    input  logic [7:0]  bus_wdata,
    output logic [7:0]  bus_rdata,
    output logic        cmd_err,
    output logic        tick_o,
    output logic [1:0]  expire_o
);
    logic [NUM_CH-1:0]  load_v;
    logic [CNT_W-1:0]   load_val;
    logic [NUM_CH-1:0]  mode_we;
    logic [MODE_W-1:0]  mode_val;
    logic [STAT_W-1:0]  ch_stat [NUM_CH];

    ivt_tick_gen #(
        .CLK_HZ  (CLK_HZ),
        .TICK_HZ (TICK_HZ)
    ) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_o (tick_o)
    );

    ivt_decoder #(
        .CNT_W  (CNT_W),
        .MODE_W (MODE_W)
    ) u_dec (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_i       (bus_wr),
        .addr_i     (bus_addr),
        .wdata_i    (bus_wdata),
        .load_o     (load_v),
        .load_val_o (load_val),
        .mode_we_o  (mode_we),
        .mode_val_o (mode_val),
        .cmd_err_o  (cmd_err)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        ivt_channel #(
            .CNT_W  (CNT_W),
            .MODE_W (MODE_W)
        ) u_ch (
            .clk        (clk),
            .rst_n      (rst_n),
            .tick_i     (tick_o),
            .load_i     (load_v[g]),
            .load_val_i (load_val),
            .mode_we_i  (mode_we[g]),
            .mode_val_i (mode_val),
            .expire_o   (expire_o[g]),
            .status_o   (ch_stat[g])
        );
    end

    always_comb begin
        unique case (bus_addr)
            A_CTRL:  bus_rdata = ch_stat[1];
            A_CH0:   bus_rdata = ch_stat[0];
            A_SPARE: bus_rdata = '0;
            A_CH2:   bus_rdata = '0;
        endcase
    end

    assert_no_err_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(bus_wr) |-> !cmd_err);

endmodule

// File: tb/interval_timer_pair_bench.sv
module interval_timer_pair_bench;
    localparam int unsigned CLK_HZ  = 1_491_475;
    localparam int unsigned TICK_HZ = 1_193_180;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic       cmd_err;
    logic       tick_o;
    logic [1:0] expire_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    interval_timer_pair #(.CLK_HZ(CLK_HZ), .TICK_HZ(TICK_HZ)) u_interval_timer_pair (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cmd_err(cmd_err),
        .tick_o(tick_o), .expire_o(expire_o)
    );

    function automatic int eff_count(input int n);
        return (n == 0) ? 65536 : n;
    endfunction

    function automatic logic [7:0] ctrl_word(input int ch, input int mode);
        return {(ch == 1) ? 2'b10 : 2'b00, 2'b11, 3'(mode), 1'b0};
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // called at a falling edge; returns at the next falling edge
    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    task automatic load(input int ch, input int n);
        logic [1:0] a;
        a = (ch == 1) ? 2'd2 : 2'd0;
        wr(a, 8'(n));
        wr(a, 8'(n >> 8));
    endtask

    task automatic watch(input int ch, input int n, input int reps, input string req);
        int ticks = 0;
        int got = 0;
        int guard = 0;
        int lim = (n * reps + 16) * 2;
        while (got < reps && guard < lim) begin
            if (expire_o[ch]) begin
                got++;
                chk(ticks == n * got, req, ticks, n * got);
            end
            if (tick_o) ticks++;
            @(negedge clk);
            guard++;
        end
        chk(got == reps, req, got, reps);
    endtask

    task automatic quiet(input int ch, input int nt, input string req);
        int ticks = 0;
        int seen = 0;
        while (ticks < nt) begin
            if (expire_o[ch]) seen++;
            if (tick_o) ticks++;
            @(negedge clk);
        end
        chk(seen == 0, req, seen, 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        int ticks;
        int seen;
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R11 reset state, R1 tick rate
        rd(2'd3, v); chk(v == 8'h00, "R11 ch2 status", v, 0);
        rd(2'd0, v); chk(v == 8'h00, "R11 ch0 status", v, 0);
        ticks = 0; seen = 0;
        for (int i = 0; i < 1000; i++) begin
            @(negedge clk);
            if (tick_o) ticks++;
            if (expire_o != 2'b00 || cmd_err) seen++;
        end
        chk(ticks >= 799 && ticks <= 801, "R1 tick count", ticks, 800);
        chk(seen == 0, "R11 idle quiet", seen, 0);

        // R8 R6 R10 one-shot on channel 2
        wr(2'd3, ctrl_word(1, 0));
        chk(cmd_err == 1'b0, "R2 legal word", cmd_err, 0);
        load(1, 10);
        rd(2'd3, v); chk(v == 8'h00, "R7 status after load", v, 0);
        watch(1, 10, 1, "R6 ch2 one-shot");
        rd(2'd3, v); chk(v == 8'h20, "R8 R10 done code", v, 32);
        quiet(1, 30, "R8 halted");

        // R9 R4 periodic on channel 0
        wr(2'd3, ctrl_word(0, 2));
        load(0, 7);
        watch(0, 7, 3, "R9 ch0 periodic");
        rd(2'd0, v); chk(v == 8'h00, "R9 R10 ch0 status", v, 0);
        wr(2'd3, ctrl_word(0, 0));
        load(0, 3);
        watch(0, 3, 1, "R4 ch0 back to one-shot");
        rd(2'd0, v); chk(v == 8'h20, "R10 ch0 status read", v, 32);

        // R5 shared byte flag, address 1 ignored
        wr(2'd0, 8'h05);
        wr(2'd1, 8'h99);
        wr(2'd2, 8'h00);
        watch(1, 5, 1, "R5 split load to ch2");
        quiet(0, 8, "R5 ch0 untouched");

        // R2 R3 rejected control words
        wr(2'd3, 8'hA4); chk(cmd_err == 1'b1, "R2 bad access bits", cmd_err, 1);
        @(negedge clk);  chk(cmd_err == 1'b0, "R2 one-cycle strobe", cmd_err, 0);
        wr(2'd3, 8'h74); chk(cmd_err == 1'b1, "R3 select 01", cmd_err, 1);
        wr(2'd3, 8'hF4); chk(cmd_err == 1'b1, "R3 select 11", cmd_err, 1);
        wr(2'd3, 8'hB5); chk(cmd_err == 1'b1, "R2 decimal request", cmd_err, 1);
        load(1, 4);
        watch(1, 4, 1, "R2 R3 mode unchanged");
        quiet(1, 12, "R2 R3 still one-shot");

        // R7 mid-count reload
        wr(2'd3, ctrl_word(1, 2));
        load(1, 50);
        quiet(1, 10, "R7 before reload");
        load(1, 6);
        watch(1, 6, 2, "R7 reload restarts");
        rd(2'd3, v); chk(v == 8'h00, "R9 periodic status", v, 0);

        // random mix
        for (int it = 0; it < 12; it++) begin
            int ch;
            int md;
            int n;
            ch = int'($urandom_range(0, 1));
            md = int'($urandom_range(0, 2));
            if (md != 0) md = md + 1;
            n = int'($urandom_range(1, 60));
            wr(2'd3, ctrl_word(ch, md));
            load(ch, n);
            watch(ch, eff_count(n), (md == 0) ? 1 : 2, "R6 R9 random");
            if (md == 0) begin
                quiet(ch, n + 3, "R8 random halt");
                rd((ch == 1) ? 2'd3 : 2'd0, v);
                chk(v == 8'h20, "R8 random status", v, 32);
            end
        end

        // R6 zero count means 65536
        wr(2'd3, ctrl_word(1, 0));
        load(1, 1);
        watch(1, 1, 1, "R6 count one");
        wr(2'd3, ctrl_word(0, 0));
        load(0, 0);
        watch(0, eff_count(0), 1, "R6 zero count");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule